// File: doc/BRIEF.md
# Flash Memory Controller with Erase Modes

This block models a flash memory controller. It holds a word array split into equal pages of main flash, and one more page of the same size that holds user configuration. A small control port reaches six controller registers: a ready indicator, a two-bit access mode, two page-erase address registers, a whole-flash erase command and a user-region erase command. A second port reads and programs words in both regions.

The access mode gates everything that changes the array. Word programming takes effect only in program mode. Erase commands take effect only in erase mode. An erase finishes in a single clock cycle and leaves every affected word at all ones. Like real flash, programming can only clear bits: the stored word becomes the old word ANDed with the written data. Reads on both ports are combinational. A write is visible on the first read after the clock edge that accepts it.

Top module: `nvm_ctrl`

## Requirements
- R1: Control offset 0 (ready) always reads 0x00000001.
- R2: Control offset 1 holds a two-bit mode that resets to 0 and reads back any written value in bits [1:0], including 3. The encodings are 0 read-only, 1 program, 2 erase and 3 reserved. Control offsets 6 and 7 read 0.
- R3: After reset, every word of the flash and the user region reads 0xFFFFFFFF.
- R4: In mode 1, a write on the memory port to an address inside the map stores old AND data, visible on the next cycle.
- R5: In modes 0, 2 and 3, writes on the memory port leave the array unchanged.
- R6: In mode 2, a write of a word address to control offset 2 or 3 sets every word of the page that contains it to all ones. The address is aligned down to a page boundary, and the neighbouring pages are unaffected.
- R7: A page-erase address at or above the flash size (PAGES*PAGE_WORDS) is ignored. This includes addresses inside the user region.
- R8: In mode 2, a write with bit 0 set to control offset 4 sets all flash words to all ones and leaves the user region unchanged.
- R9: In mode 2, a write with bit 0 set to control offset 5 sets all user-region words to all ones and leaves flash unchanged.
- R10: Writes to control offsets 2 to 5 have no effect when the mode is not 2. Writes to offsets 4 and 5 also have no effect when bit 0 of the data is 0.
- R11: Memory-port word addresses 0 to PAGES*PAGE_WORDS-1 reach flash. The next PAGE_WORDS addresses reach the user region. Reads above that return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_addr | input | 3 | Control register word offset |
| ctl_wdata | input | 32 | Control write data |
| ctl_rdata | output | 32 | Control read data for ctl_addr |
| mem_wr | input | 1 | Memory-port write (program) strobe |
| mem_addr | input | AW (11 by default) | Memory word address |
| mem_wdata | input | 32 | Memory program data |
| mem_rdata | output | 32 | Memory read data for mem_addr |

## Verification
The assertions check on every cycle that the ready register reads 1 and that a mode write is taken. They also check that a program in mode 1 only clears bits of the addressed word, that the array holds still when no enabled operation touches it, and that all flash words read all ones right after a whole-flash erase. Some effects can only be shown by the bench's scenarios, because they concern words other than the one on the read port. These are page alignment of unaligned erase addresses, the untouched neighbour pages, out-of-range erase addresses, and the separation between flash and the user region under the two bulk erases.

// File: rtl/nvm_ctrl_pkg.sv
package nvm_ctrl_pkg;
    typedef enum logic [1:0] {
        MODE_READ  = 2'd0,
        MODE_PROG  = 2'd1,
        MODE_ERASE = 2'd2,
        MODE_RSVD  = 2'd3
    } mode_e;

    localparam int CTL_AW = 3;
    localparam logic [CTL_AW-1:0] CTL_READY = 3'd0;
    localparam logic [CTL_AW-1:0] CTL_MODE  = 3'd1;
    localparam logic [CTL_AW-1:0] CTL_PG_A  = 3'd2;
    localparam logic [CTL_AW-1:0] CTL_PG_B  = 3'd3;
    localparam logic [CTL_AW-1:0] CTL_CHIP  = 3'd4;
    localparam logic [CTL_AW-1:0] CTL_USER  = 3'd5;

    typedef struct packed {
        mode_e mode;
    } ctl_state_t;
endpackage

// File: rtl/nvm_ctl_regs.sv
module nvm_ctl_regs
    import nvm_ctrl_pkg::*;
#(
    parameter int DW         = 32,
    parameter int PAGE_WORDS = 256,
    parameter int PAGES      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_AW-1:0] ctl_addr,
    input  logic [DW-1:0]     ctl_wdata,
    output logic [DW-1:0]     ctl_rdata,
    output mode_e             mode,
    output logic [PAGES:0]    page_erase
);
    localparam int FLASH_WORDS = PAGES * PAGE_WORDS;
    localparam int NPG         = PAGES + 1;

    ctl_state_t st_d, st_q;
    logic [DW-1:0] pg_full;

    assign pg_full = ctl_wdata / DW'(PAGE_WORDS);

    always_comb begin
        st_d       = st_q;
        page_erase = '0;
        if (ctl_wr) begin
            case (ctl_addr)
                CTL_MODE: st_d.mode = mode_e'(ctl_wdata[1:0]);
                CTL_PG_A, CTL_PG_B: begin
                    if (st_q.mode == MODE_ERASE && ctl_wdata < DW'(FLASH_WORDS)) begin
                        for (int p = 0; p < PAGES; p++) begin
                            if (pg_full == DW'(p)) page_erase[p] = 1'b1;
                        end
                    end
                end
                CTL_CHIP: begin
                    if (st_q.mode == MODE_ERASE && ctl_wdata[0])
                        page_erase[PAGES-1:0] = '1;
                end
                CTL_USER: begin
                    if (st_q.mode == MODE_ERASE && ctl_wdata[0])
                        page_erase[NPG-1] = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (ctl_addr)
            CTL_READY: ctl_rdata = DW'(1);
            CTL_MODE:  ctl_rdata = DW'(st_q.mode);
            default:   ctl_rdata = '0;
        endcase
    end

    assign mode = st_q.mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_READ};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/nvm_page.sv
module nvm_page #(
    parameter int DW    = 32,
    parameter int WORDS = 256,
    localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          erase,
    input  logic          wr_en,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] words_d [WORDS];
    logic [DW-1:0] words_q [WORDS];

    always_comb begin
        words_d = words_q;
        if (erase) begin
            for (int i = 0; i < WORDS; i++) words_d[i] = '1;
        end else if (wr_en) begin
            words_d[idx] = words_q[idx] & wr_data;
        end
    end

    assign rd_data = words_q[idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) words_q[i] <= '1;
        end else begin
            words_q <= words_d;
        end
    end
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
    import nvm_ctrl_pkg::*;
#(
    parameter int DW         = 32,
    parameter int PAGE_WORDS = 256,
    parameter int PAGES      = 4,
    localparam int TOTAL     = (PAGES + 1) * PAGE_WORDS,
    localparam int AW        = $clog2(TOTAL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_AW-1:0] ctl_addr,
    input  logic [DW-1:0]     ctl_wdata,
    output logic [DW-1:0]     ctl_rdata,
    input  logic              mem_wr,
    input  logic [AW-1:0]     mem_addr,
    input  logic [DW-1:0]     mem_wdata,
    output logic [DW-1:0]     mem_rdata
);
    localparam int NPG = PAGES + 1;
    localparam int IW  = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1;

    mode_e          mode;
    logic [PAGES:0] page_erase;
    logic           in_range;
    logic [AW-1:0]  pg_sel;
    logic [AW-1:0]  offs_full;
    logic [IW-1:0]  offs;
    logic [DW-1:0]  page_rd [NPG];

    assign in_range  = mem_addr < AW'(TOTAL);
    assign pg_sel    = mem_addr / AW'(PAGE_WORDS);
    assign offs_full = mem_addr % AW'(PAGE_WORDS);
    assign offs      = offs_full[IW-1:0];

    nvm_ctl_regs #(.DW(DW), .PAGE_WORDS(PAGE_WORDS), .PAGES(PAGES)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_addr   (ctl_addr),
        .ctl_wdata  (ctl_wdata),
        .ctl_rdata  (ctl_rdata),
        .mode       (mode),
        .page_erase (page_erase)
    );

    for (genvar p = 0; p < NPG; p++) begin : g_page
        logic wr_en;
        assign wr_en = mem_wr && in_range && (mode == MODE_PROG) && (pg_sel == AW'(p));
        nvm_page #(.DW(DW), .WORDS(PAGE_WORDS)) u_page (
            .clk     (clk),
            .rst_n   (rst_n),
            .erase   (page_erase[p]),
            .wr_en   (wr_en),
            .idx     (offs),
            .wr_data (mem_wdata),
            .rd_data (page_rd[p])
        );
    end

    always_comb begin
        mem_rdata = '0;
        for (int p = 0; p < NPG; p++) begin
            if (in_range && pg_sel == AW'(p)) mem_rdata = page_rd[p];
        end
    end
endmodule

// File: rtl/nvm_ctrl_chk.sv
module nvm_ctrl_chk
    import nvm_ctrl_pkg::*;
#(
    parameter int DW         = 32,
    parameter int PAGE_WORDS = 256,
    parameter int PAGES      = 4,
    parameter int AW         = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_wr,
    input logic [CTL_AW-1:0] ctl_addr,
    input logic [DW-1:0]     ctl_wdata,
    input logic [DW-1:0]     ctl_rdata,
    input logic              mem_wr,
    input logic [AW-1:0]     mem_addr,
    input logic [DW-1:0]     mem_wdata,
    input logic [DW-1:0]     mem_rdata,
    input mode_e             mode
);
    localparam int FLASH_WORDS = PAGES * PAGE_WORDS;

    a_r1_ready_one: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_addr == CTL_READY) |-> (ctl_rdata == DW'(1)));

    a_r2_mode_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_addr == CTL_MODE) |=> (mode == mode_e'($past(ctl_wdata[1:0]))));

    a_r4_program_clears_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mode == MODE_PROG) |=>
        ((mem_addr != $past(mem_addr)) || (mem_rdata == ($past(mem_rdata) & $past(mem_wdata)))));

    a_r5_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mode != MODE_PROG && !ctl_wr) |=>
        ((mem_addr != $past(mem_addr)) || (mem_rdata == $past(mem_rdata))));

    a_r10_no_erase_outside_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr && mode != MODE_ERASE) |=>
        ((mem_addr != $past(mem_addr)) || (mem_rdata == $past(mem_rdata))));

    a_r8_chip_erased: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_addr == CTL_CHIP && ctl_wdata[0] && mode == MODE_ERASE) |=>
        ((mem_addr >= AW'(FLASH_WORDS)) || (mem_rdata == '1)));
endmodule

bind nvm_ctrl nvm_ctrl_chk #(
    .DW(DW), .PAGE_WORDS(PAGE_WORDS), .PAGES(PAGES), .AW(AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_addr  (ctl_addr),
    .ctl_wdata (ctl_wdata),
    .ctl_rdata (ctl_rdata),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mode      (mode)
);

// File: tb/nvm_ctrl_tb.sv
module nvm_ctrl_tb;
    localparam int PW = 256;
    localparam int NP = 4;
    localparam int FW = PW * NP;
    localparam int UB = FW;
    localparam int AW = $clog2((NP + 1) * PW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_wr = 1'b0;
    logic [2:0]    ctl_addr = '0;
    logic [31:0]   ctl_wdata = '0;
    logic [31:0]   ctl_rdata;
    logic          mem_wr = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic [31:0]   mem_wdata = '0;
    logic [31:0]   mem_rdata;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    nvm_ctrl #(.PAGE_WORDS(PW), .PAGES(NP)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_addr = a; ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic ctl_read(input logic [2:0] a, output logic [31:0] d);
        ctl_addr = a; #1; d = ctl_rdata;
    endtask

    task automatic mem_write(input int a, input logic [31:0] d);
        @(negedge clk);
        mem_wr = 1'b1; mem_addr = AW'(a); mem_wdata = d;
        @(negedge clk);
        mem_wr = 1'b0;
    endtask

    task automatic mem_read(input int a, output logic [31:0] d);
        mem_addr = AW'(a); #1; d = mem_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        ctl_read(3'd0, v); chk("R1 ready", v, 32'h1);
        ctl_read(3'd1, v); chk("R2 mode reset", v, 32'h0);
        mem_read(0, v);      chk("R3 word 0", v, 32'hFFFFFFFF);
        mem_read(FW - 1, v); chk("R3 last flash", v, 32'hFFFFFFFF);
        mem_read(UB, v);     chk("R3 user first", v, 32'hFFFFFFFF);
        mem_read(UB + PW - 1, v); chk("R3 user last", v, 32'hFFFFFFFF);
        mem_read(UB + PW + 5, v); chk("R11 beyond map", v, 32'h0);
    endtask

    task automatic t_mode();
        logic [31:0] v;
        for (int m = 1; m < 5; m++) begin
            ctl_write(3'd1, 32'(m % 4) | 32'hFFFF_FFF0);
            ctl_read(3'd1, v); chk("R2 mode readback", v, 32'(m % 4));
        end
        ctl_read(3'd6, v); chk("R2 offset 6", v, 32'h0);
        ctl_read(3'd7, v); chk("R2 offset 7", v, 32'h0);
        ctl_read(3'd0, v); chk("R1 ready after mode writes", v, 32'h1);
    endtask

    task automatic t_program();
        logic [31:0] v;
        ctl_write(3'd1, 32'd1);
        mem_write(5, 32'h12345678);
        mem_read(5, v); chk("R4 program", v, 32'h12345678);
        mem_write(5, 32'hFFFF0000);
        mem_read(5, v); chk("R4 and-only", v, 32'h12340000);
        mem_write(5, 32'hFFFFFFFF);
        mem_read(5, v); chk("R4 ones keep", v, 32'h12340000);
        mem_write(UB + 7, 32'hA5A5A5A5);
        mem_read(UB + 7, v); chk("R11 user program", v, 32'hA5A5A5A5);
        mem_read(6, v); chk("R4 neighbour", v, 32'hFFFFFFFF);
    endtask

    task automatic t_write_locked();
        logic [31:0] v;
        for (int m = 0; m < 4; m++) begin
            if (m == 1) continue;
            ctl_write(3'd1, 32'(m));
            mem_write(9, 32'h0);
            mem_read(9, v); chk("R5 write ignored", v, 32'hFFFFFFFF);
        end
    endtask

    task automatic t_page_erase();
        logic [31:0] v;
        ctl_write(3'd1, 32'd1);
        mem_write(255, 32'h0);
        mem_write(256, 32'h0);
        mem_write(259, 32'h0);
        mem_write(511, 32'h0);
        mem_write(512, 32'h0);
        ctl_write(3'd2, 32'd1);
        mem_read(256, v); chk("R10 page erase in mode 1", v, 32'h0);
        ctl_write(3'd1, 32'd2);
        ctl_write(3'd2, 32'd300);
        mem_read(256, v); chk("R6 aligned start", v, 32'hFFFFFFFF);
        mem_read(259, v); chk("R6 inside page", v, 32'hFFFFFFFF);
        mem_read(511, v); chk("R6 page end", v, 32'hFFFFFFFF);
        mem_read(255, v); chk("R6 lower neighbour", v, 32'h0);
        mem_read(512, v); chk("R6 upper neighbour", v, 32'h0);
        ctl_write(3'd3, 32'd529);
        mem_read(512, v); chk("R6 second register", v, 32'hFFFFFFFF);
        mem_read(255, v); chk("R6 other page kept", v, 32'h0);
    endtask

    task automatic t_page_oor();
        logic [31:0] v;
        ctl_write(3'd2, 32'(UB + 3));
        mem_read(UB + 7, v); chk("R7 user addr ignored", v, 32'hA5A5A5A5);
        ctl_write(3'd3, 32'd5000);
        mem_read(5, v); chk("R7 far addr ignored", v, 32'h12340000);
        mem_read(255, v); chk("R7 far addr page 0", v, 32'h0);
    endtask

    task automatic t_erase_guard();
        logic [31:0] v;
        ctl_write(3'd4, 32'd0);
        mem_read(5, v); chk("R10 chip bit0 clear", v, 32'h12340000);
        ctl_write(3'd5, 32'd2);
        mem_read(UB + 7, v); chk("R10 user bit0 clear", v, 32'hA5A5A5A5);
        ctl_write(3'd1, 32'd3);
        ctl_write(3'd4, 32'd1);
        mem_read(5, v); chk("R10 chip in mode 3", v, 32'h12340000);
        ctl_write(3'd1, 32'd0);
        ctl_write(3'd5, 32'd1);
        mem_read(UB + 7, v); chk("R10 user in mode 0", v, 32'hA5A5A5A5);
    endtask

    task automatic t_chip();
        logic [31:0] v;
        ctl_write(3'd1, 32'd2);
        ctl_write(3'd4, 32'd1);
        mem_read(5, v);   chk("R8 word 5", v, 32'hFFFFFFFF);
        mem_read(255, v); chk("R8 word 255", v, 32'hFFFFFFFF);
        mem_read(UB + 7, v); chk("R8 user kept", v, 32'hA5A5A5A5);
    endtask

    task automatic t_user();
        logic [31:0] v;
        ctl_write(3'd1, 32'd1);
        mem_write(100, 32'h0F0F0000);
        ctl_write(3'd1, 32'd2);
        ctl_write(3'd5, 32'd1);
        mem_read(UB + 7, v); chk("R9 user erased", v, 32'hFFFFFFFF);
        mem_read(100, v); chk("R9 flash kept", v, 32'h0F0F0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode();
        t_program();
        t_write_locked();
        t_page_erase();
        t_page_oor();
        t_erase_guard();
        t_chip();
        t_user();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule